// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration register image of a single function and serves it to a host through a type 1 style routing address. Each request carries a 32-bit address whose bits 23:16 name a bus, bits 15:8 a device/function number and bits 7:0 a byte offset. When bus and device/function match the block's parameters, a read returns one, two or four bytes in little-endian order, and a write merges new data into the image one byte at a time. Each byte has a fixed writable mask, so read-only fields keep their value whatever is written to them.

The writable masks are derived from parameters. The command register exposes only its I/O-enable, memory-enable and bus-master bits. The cache line size and interrupt line bytes are fully writable, and so is the whole area from offset 0x40 upward. Each implemented base address register takes its mask from its region size, and the expansion ROM register also has a writable enable bit. Reads that would run past the last byte fall back to a narrower size. Reads of an absent target return all ones, and writes to an absent target are discarded. After any write that alters a base address register byte or toggles a decode-enable command bit, a one-cycle remap strobe tells the surrounding logic to rebuild its address windows.

Top module: `cfg_space_top`

## Requirements
- R1: A write of one, two or four bytes (req_size 0, 1, 2; 3 acts as 2) at offset N updates byte N+k from req_wdata bits 8k+7:8k. Each byte becomes (old AND NOT mask) OR (new AND mask). When no write hits, the register image stays unchanged.
- R2: Bytes of a write that would fall beyond offset 0xFF are dropped and do not wrap to the bottom of the space.
- R3: Offsets 0x0C and 0x3C are fully writable. In the command byte at 0x04, only bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) are writable.
- R4: Every byte from 0x40 to 0xFF is fully writable. All other header bytes not named in R3 or R5 are read-only, for example the ID bytes 0x00-0x03 (vendor ID low half, device ID high half) and 0x08-0x0B.
- R5: Base address register b sits at offset 0x10+4b. If b < NUM_BARS, its mask is ~(2^BAR_SIZE_LOG2 - 1) and its reset value has bit 0 equal to BAR_IO_MASK[b]. Otherwise it reads zero. The ROM register at 0x30 has the mask ~(2^ROM_SIZE_LOG2 - 1) | 1.
- R6: A dword read at an offset above 0xFC returns a word, and a word read above 0xFE returns a single byte. In both cases the upper bits are zero.
- R7: rd_valid is high exactly in the cycle after a read request, and rd_data holds the read result in that cycle.
- R8: The target is present only when address bits 23:16 equal BUS_SEL and bits 15:8 equal DEVFN_SEL. Bits 31:24 are ignored.
- R9: A read of an absent target returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word and dword size.
- R10: A write to an absent target changes nothing and raises no remap strobe.
- R11: remap_pulse is high for exactly one cycle after a write that changes any byte in 0x10-0x27, or that toggles command bit 0 or 1. A write that leaves those bytes and bits unchanged gives no pulse.
- R12: After reset, rd_valid and remap_pulse are low. The image is zero except for the ID bytes and the I/O type bits of the base address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 dword |
| req_addr | input | 32 | Routing address: bus 23:16, device/function 15:8, offset 7:0 |
| req_wdata | input | 32 | Write data, little-endian from the offset |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| remap_pulse | output | 1 | One-cycle request to rebuild address decoding |

## Verification
The hardest case to reach is the remap strobe, because it depends on whether a stored value actually changes rather than on whether a write happened. Several writes are therefore arranged so that they look like remap triggers but must stay silent: a base address register rewritten with the value it already holds, an all-ones write to an unimplemented base register, a command write that flips only the bus-master bit, and writes to absent targets whose offsets fall inside the base register window. Top-of-space fallback reads follow partial writes near 0xFF, so each returned byte comes from a known lane.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

   localparam int unsigned CFG_BYTES = 256;
   localparam int unsigned OFF_W     = 8;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_ALT   = 2'd3
   } acc_size_e;

   // writable bits of the byte at offset off
   function automatic logic [7:0] byte_wmask(input int unsigned off,
                                             input int unsigned nbars,
                                             input int unsigned bar_lg,
                                             input bit          rom_en,
                                             input int unsigned rom_lg);
      logic [31:0] m;
      m = 32'd0;
      if (off == 4) begin
         m = 32'h0000_0007;
      end else if (off == 12 || off == 60 || off >= 64) begin
         m = 32'h0000_00FF;
      end else if (off >= 16 && off < 40) begin
         if (((off - 16) / 4) < nbars) begin
            m = ~((32'd1 << bar_lg) - 32'd1);
            m = m >> (8 * (off % 4));
         end
      end else if (off >= 48 && off < 52 && rom_en) begin
         m = ~((32'd1 << rom_lg) - 32'd1) | 32'd1;
         m = m >> (8 * (off % 4));
      end
      return m[7:0];
   endfunction

   // reset content of the byte at offset off
   function automatic logic [7:0] byte_reset(input int unsigned off,
                                             input logic [15:0] vendor,
                                             input logic [15:0] device,
                                             input int unsigned nbars,
                                             input logic [5:0]  io_mask);
      logic [7:0] v;
      v = 8'd0;
      case (off)
         0: v = vendor[7:0];
         1: v = vendor[15:8];
         2: v = device[7:0];
         3: v = device[15:8];
         default: begin
            if (off >= 16 && off < 40 && (off % 4) == 0 &&
                ((off - 16) / 4) < nbars)
               v = {7'd0, io_mask[(off - 16) / 4]};
         end
      endcase
      return v;
   endfunction

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode #(
   parameter logic [7:0] BUS_SEL   = 8'h00,
   parameter logic [7:0] DEVFN_SEL = 8'h18
) (
   input  logic [31:0] addr,
   output logic        hit,
   output logic [7:0]  offset
);

   always_comb begin
      hit    = (addr[23:16] == BUS_SEL) && (addr[15:8] == DEVFN_SEL);
      offset = addr[7:0];
   end

endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
   import cfg_pkg::*;
#(
   parameter int unsigned NUM_BARS      = 2,
   parameter int unsigned BAR_SIZE_LOG2 = 8,
   parameter logic [5:0]  BAR_IO_MASK   = 6'b000010,
   parameter bit          ROM_PRESENT   = 1'b1,
   parameter int unsigned ROM_SIZE_LOG2 = 11,
   parameter logic [15:0] VENDOR_ID     = 16'hABCD,
   parameter logic [15:0] DEVICE_ID     = 16'h1234
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [OFF_W-1:0]                  wr_off,
   input  logic [1:0]                        wr_size,
   input  logic [31:0]                       wr_data,
   output logic [CFG_BYTES-1:0][7:0]         image,
   output logic                              remap_req
);

   localparam int unsigned BAR_LO = 16;
   localparam int unsigned BAR_HI = 40;
   localparam int unsigned CMD_OFF = 4;

   logic [2:0]           nbytes;
   logic [CFG_BYTES-1:0] chg;

   always_comb begin
      case (acc_size_e'(wr_size))
         SZ_BYTE: nbytes = 3'd1;
         SZ_WORD: nbytes = 3'd2;
         default: nbytes = 3'd4;
      endcase
   end

   for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
      localparam logic [7:0] WM  = byte_wmask(i, NUM_BARS, BAR_SIZE_LOG2,
                                              ROM_PRESENT, ROM_SIZE_LOG2);
      localparam logic [7:0] RST = byte_reset(i, VENDOR_ID, DEVICE_ID,
                                              NUM_BARS, BAR_IO_MASK);
      if (WM == 8'd0) begin : g_const
         assign image[i] = RST;
         assign chg[i]   = 1'b0;
      end else begin : g_reg
         logic [7:0] rel;
         logic       in_win;
         logic [7:0] lane;
         logic [7:0] nxt;
         logic [7:0] cur;

         always_comb begin
            rel    = 8'(i) - wr_off;
            in_win = (8'(i) >= wr_off) && (rel < {5'd0, nbytes});
            lane   = wr_data[{rel[1:0], 3'b000} +: 8];
            nxt    = (cur & ~WM) | (lane & WM);
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               cur <= RST;
            else if (wr_en && in_win)
               cur <= nxt;
         end

         assign image[i] = cur;

         if (i >= BAR_LO && i < BAR_HI) begin : g_bar_chg
            assign chg[i] = wr_en && in_win && (nxt != cur);
         end else if (i == CMD_OFF) begin : g_cmd_chg
            assign chg[i] = wr_en && in_win && (((nxt ^ cur) & 8'h03) != 8'd0);
         end else begin : g_no_chg
            assign chg[i] = 1'b0;
         end
      end
   end

   assign remap_req = |chg;

   // R1: with no write hitting, the image holds
   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(image));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfg_pkg::*;
(
   input  logic [CFG_BYTES-1:0][7:0] image,
   input  logic                      hit,
   input  logic [OFF_W-1:0]          off,
   input  logic [1:0]                size,
   output logic [31:0]               data
);

   localparam logic [7:0] DW_LAST = 8'hFC;
   localparam logic [7:0] WD_LAST = 8'hFE;

   logic [7:0] b0, b1, b2, b3;

   always_comb begin
      b0 = image[off];
      b1 = image[off + 8'd1];
      b2 = image[off + 8'd2];
      b3 = image[off + 8'd3];
      if (!hit) begin
         case (acc_size_e'(size))
            SZ_BYTE: data = 32'h0000_00FF;
            SZ_WORD: data = 32'h0000_FFFF;
            default: data = 32'hFFFF_FFFF;
         endcase
      end else if (size[1] && off <= DW_LAST) begin
         data = {b3, b2, b1, b0};
      end else if ((size != 2'd0) && off <= WD_LAST) begin
         data = {16'd0, b1, b0};
      end else begin
         data = {24'd0, b0};
      end
   end

endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
   import cfg_pkg::*;
#(
   parameter logic [7:0]  BUS_SEL       = 8'h00,
   parameter logic [7:0]  DEVFN_SEL     = 8'h18,
   parameter int unsigned NUM_BARS      = 2,
   parameter int unsigned BAR_SIZE_LOG2 = 8,
   parameter logic [5:0]  BAR_IO_MASK   = 6'b000010,
   parameter bit          ROM_PRESENT   = 1'b1,
   parameter int unsigned ROM_SIZE_LOG2 = 11,
   parameter logic [15:0] VENDOR_ID     = 16'hABCD,
   parameter logic [15:0] DEVICE_ID     = 16'h1234
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [1:0]  req_size,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   output logic        remap_pulse
);

   localparam int unsigned MAX_BARS = 6;

   if (NUM_BARS > MAX_BARS) begin : g_bad_bars
      $error("NUM_BARS exceeds the base register window");
   end
   if (BAR_SIZE_LOG2 < 2 || BAR_SIZE_LOG2 > 31) begin : g_bad_bar_size
      $error("BAR_SIZE_LOG2 out of range");
   end
   if (ROM_SIZE_LOG2 < 11 || ROM_SIZE_LOG2 > 31) begin : g_bad_rom_size
      $error("ROM_SIZE_LOG2 out of range");
   end

   logic                      hit;
   logic [OFF_W-1:0]          off;
   logic [CFG_BYTES-1:0][7:0] image;
   logic                      remap_req;
   logic [31:0]               rd_next;
   logic                      do_read;
   logic                      do_write;

   cfg_route_decode #(
      .BUS_SEL  (BUS_SEL),
      .DEVFN_SEL(DEVFN_SEL)
   ) i_decode (
      .addr  (req_addr),
      .hit   (hit),
      .offset(off)
   );

   assign do_read  = req_valid && !req_write;
   assign do_write = req_valid && req_write && hit;

   cfg_byte_array #(
      .NUM_BARS     (NUM_BARS),
      .BAR_SIZE_LOG2(BAR_SIZE_LOG2),
      .BAR_IO_MASK  (BAR_IO_MASK),
      .ROM_PRESENT  (ROM_PRESENT),
      .ROM_SIZE_LOG2(ROM_SIZE_LOG2),
      .VENDOR_ID    (VENDOR_ID),
      .DEVICE_ID    (DEVICE_ID)
   ) i_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (do_write),
      .wr_off   (off),
      .wr_size  (req_size),
      .wr_data  (req_wdata),
      .image    (image),
      .remap_req(remap_req)
   );

   cfg_read_mux i_rmux (
      .image(image),
      .hit  (hit),
      .off  (off),
      .size (req_size),
      .data (rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_data     <= 32'd0;
         remap_pulse <= 1'b0;
      end else begin
         rd_valid    <= do_read;
         remap_pulse <= remap_req;
         if (do_read)
            rd_data <= rd_next;
      end
   end

   // R7: read result appears exactly one cycle after the request
   assert_rd_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);
   assert_rd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);

   // R9: absent byte read yields all ones in the low byte
   assert_miss_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !hit && req_size == 2'd0) |=>
      (rd_data == 32'h0000_00FF));

   // R10: a write that misses raises no strobe
   assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !hit) |=> !remap_pulse);

   // R11: a strobe is always caused by a hitting write one cycle earlier
   assert_remap_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      remap_pulse |-> $past(req_valid && req_write && hit));

endmodule

// File: tb/test_cfg_space_top.sv
module test_cfg_space_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = 32'd0;
   logic [31:0] req_wdata = 32'd0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        remap_pulse;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cfg_space_top i_cfg_space_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .remap_pulse(remap_pulse)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic [31:0] addr;
      logic [31:0] data;   // write data, or expected read data
      logic        rmp;    // expected strobe after a write
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 47;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b0, 2'd2, 32'h0000_1814, 32'h0000_0001, 1'b0, 4'd5},  // R5 io type bit at reset
      '{1'b1, 2'd2, 32'h0000_1810, 32'hFFFF_FFFF, 1'b1, 4'd11}, // R11 BAR0 changes
      '{1'b0, 2'd2, 32'h0000_1810, 32'hFFFF_FF00, 1'b0, 4'd5},  // R5
      '{1'b1, 2'd2, 32'h0000_1814, 32'hFFFF_FFFF, 1'b1, 4'd11}, // R11
      '{1'b0, 2'd2, 32'h0000_1814, 32'hFFFF_FF01, 1'b0, 4'd5},  // R5
      '{1'b1, 2'd2, 32'h0000_1818, 32'hFFFF_FFFF, 1'b0, 4'd11}, // R11 absent BAR, no change
      '{1'b0, 2'd2, 32'h0000_1818, 32'h0000_0000, 1'b0, 4'd5},  // R5
      '{1'b1, 2'd2, 32'h0000_1830, 32'hFFFF_FFFF, 1'b0, 4'd11}, // R11 ROM outside window
      '{1'b0, 2'd2, 32'h0000_1830, 32'hFFFF_F801, 1'b0, 4'd5},  // R5 ROM mask
      '{1'b1, 2'd2, 32'h0000_1810, 32'hFFFF_FFFF, 1'b0, 4'd11}, // R11 same value
      '{1'b1, 2'd0, 32'h0000_1804, 32'h0000_00FC, 1'b0, 4'd11}, // R11 bus master only
      '{1'b0, 2'd1, 32'h0000_1804, 32'h0000_0004, 1'b0, 4'd3},  // R3
      '{1'b1, 2'd1, 32'h0000_1804, 32'h0000_FFFF, 1'b1, 4'd11}, // R11 enables toggle
      '{1'b0, 2'd2, 32'h0000_1804, 32'h0000_0007, 1'b0, 4'd3},  // R3
      '{1'b1, 2'd1, 32'h0000_1804, 32'h0000_0007, 1'b0, 4'd11}, // R11 no change
      '{1'b1, 2'd0, 32'h0000_1804, 32'h0000_0005, 1'b1, 4'd11}, // R11 memory enable off
      '{1'b1, 2'd0, 32'h0000_180C, 32'h0000_00A5, 1'b0, 4'd3},  // R3
      '{1'b0, 2'd0, 32'h0000_180C, 32'h0000_00A5, 1'b0, 4'd3},  // R3
      '{1'b1, 2'd2, 32'h0000_183C, 32'h1122_3344, 1'b0, 4'd3},  // R3
      '{1'b0, 2'd2, 32'h0000_183C, 32'h0000_0044, 1'b0, 4'd3},  // R3
      '{1'b1, 2'd2, 32'h0000_1808, 32'hFFFF_FFFF, 1'b0, 4'd4},  // R4
      '{1'b0, 2'd2, 32'h0000_1808, 32'h0000_0000, 1'b0, 4'd4},  // R4 read-only
      '{1'b1, 2'd2, 32'h0000_1840, 32'hDEAD_BEEF, 1'b0, 4'd4},  // R4
      '{1'b0, 2'd2, 32'h0000_1840, 32'hDEAD_BEEF, 1'b0, 4'd4},  // R4
      '{1'b1, 2'd1, 32'h0000_1842, 32'h0000_1234, 1'b0, 4'd1},  // R1
      '{1'b0, 2'd2, 32'h0000_1840, 32'h1234_BEEF, 1'b0, 4'd1},  // R1
      '{1'b0, 2'd0, 32'h0000_1841, 32'h0000_00BE, 1'b0, 4'd1},  // R1
      '{1'b0, 2'd1, 32'h0000_1841, 32'h0000_34BE, 1'b0, 4'd1},  // R1
      '{1'b1, 2'd2, 32'h0000_18FC, 32'h4433_2211, 1'b0, 4'd1},  // R1
      '{1'b0, 2'd2, 32'h0000_18FD, 32'h0000_3322, 1'b0, 4'd6},  // R6 dword to word
      '{1'b0, 2'd2, 32'h0000_18FF, 32'h0000_0044, 1'b0, 4'd6},  // R6 dword to byte
      '{1'b0, 2'd1, 32'h0000_18FF, 32'h0000_0044, 1'b0, 4'd6},  // R6 word to byte
      '{1'b0, 2'd2, 32'h0000_18FC, 32'h4433_2211, 1'b0, 4'd6},  // R6
      '{1'b1, 2'd2, 32'h0000_18FE, 32'hAABB_CCDD, 1'b0, 4'd2},  // R2
      '{1'b0, 2'd2, 32'h0000_18FC, 32'hCCDD_2211, 1'b0, 4'd2},  // R2
      '{1'b0, 2'd2, 32'h0000_1800, 32'h1234_ABCD, 1'b0, 4'd2},  // R2 no wrap
      '{1'b0, 2'd0, 32'h0001_1840, 32'h0000_00FF, 1'b0, 4'd9},  // R9
      '{1'b0, 2'd1, 32'h0001_1840, 32'h0000_FFFF, 1'b0, 4'd9},  // R9
      '{1'b0, 2'd2, 32'h0000_2040, 32'hFFFF_FFFF, 1'b0, 4'd9},  // R9
      '{1'b0, 2'd3, 32'h0000_2040, 32'hFFFF_FFFF, 1'b0, 4'd9},  // R9
      '{1'b1, 2'd2, 32'h0000_2040, 32'h0000_0000, 1'b0, 4'd10}, // R10
      '{1'b1, 2'd2, 32'h0001_1840, 32'h0000_0000, 1'b0, 4'd10}, // R10
      '{1'b1, 2'd2, 32'h0000_2010, 32'h0000_0000, 1'b0, 4'd10}, // R10
      '{1'b0, 2'd2, 32'hFF00_1840, 32'h1234_BEEF, 1'b0, 4'd8},  // R8 and R10
      '{1'b0, 2'd2, 32'h0000_1810, 32'hFFFF_FF00, 1'b0, 4'd10}, // R10
      '{1'b1, 2'd1, 32'h0000_1812, 32'h0000_ABCD, 1'b1, 4'd11}, // R11 word in BAR
      '{1'b0, 2'd2, 32'h0000_1810, 32'hABCD_FF00, 1'b0, 4'd5}   // R5
   };

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one request, then sample the registered outputs at the next falling edge
   task automatic issue(input logic wr, input logic [1:0] sz,
                        input logic [31:0] addr, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_size  = sz;
      req_addr  = addr;
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state of the outputs
      check("R12 rd_valid", {31'd0, rd_valid}, 32'd0);
      check("R12 remap_pulse", {31'd0, remap_pulse}, 32'd0);
      issue(1'b0, 2'd2, 32'h0000_1800, 32'd0);
      check("R12 ids", rd_data, 32'h1234_ABCD);
      check("R7 rd_valid", {31'd0, rd_valid}, 32'd1);
      @(negedge clk);
      check("R7 rd_valid idle", {31'd0, rd_valid}, 32'd0);

      for (int k = 0; k < NV; k++) begin
         issue(VECS[k].wr, VECS[k].sz, VECS[k].addr, VECS[k].data);
         if (VECS[k].wr) begin
            check($sformatf("vec %0d R%0d strobe", k, VECS[k].req),
                  {31'd0, remap_pulse}, {31'd0, VECS[k].rmp});
            check($sformatf("vec %0d R7 no read", k),
                  {31'd0, rd_valid}, 32'd0);
         end else begin
            check($sformatf("vec %0d R7 valid", k),
                  {31'd0, rd_valid}, 32'd1);
            check($sformatf("vec %0d R%0d data", k, VECS[k].req),
                  rd_data, VECS[k].data);
         end
      end

      // R11 strobe lasts one cycle
      issue(1'b1, 2'd2, 32'h0000_1810, 32'h0000_0000);
      check("R11 strobe", {31'd0, remap_pulse}, 32'd1);
      @(negedge clk);
      check("R11 strobe single", {31'd0, remap_pulse}, 32'd0);

      // R12 reset mid-run restores the image
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      issue(1'b0, 2'd2, 32'h0000_1814, 32'd0);
      check("R12 BAR1 after reset", rd_data, 32'h0000_0001);
      issue(1'b0, 2'd2, 32'h0000_1840, 32'd0);
      check("R12 user area after reset", rd_data, 32'h0000_0000);
      issue(1'b0, 2'd1, 32'h0000_1804, 32'd0);
      check("R12 command after reset", rd_data, 32'h0000_0000);

      done = 1'b1;
      summary();
   end

endmodule